// File: doc/BRIEF.md
# Big-Endian Instruction Length Classifier

This block looks at the leading halfword of an instruction held in big-endian byte order and decides how long that instruction is. In big-endian order the major opcode is always in the first two bytes, so one halfword is enough to tell the instruction's size. This holds whatever byte order the data path uses. When the escape mode is on, the row of the opcode map whose top three opcode bits are zero is split into four pairs. Each pair marks one special class: 16-bit compressed, 48-bit prefixed, 64-bit prefixed, or a variable-length block. Every other opcode marks a plain 32-bit instruction. Each special class leaves eleven payload bits in the halfword.

The result is registered one cycle after the halfword is presented. It gives a class code, the byte length for the fixed-size classes, and the payload field. A small aligner keeps a stream pointer. For each accepted halfword it moves the pointer forward by the decoded length. When it meets a variable-length block, whose length it cannot know, it stops and raises a flag. It stays stopped until an external load gives it a new pointer.

Top module: `ilen_classifier`

## Requirements
- R1: `cls_valid` is high in exactly the cycle after a cycle with `hw_valid` high. `cls_code`, `len_bytes` and `payload` are updated in that same cycle.
- R2: With `esc_en` high and `hw_data[15:13]` equal to 000, bits `hw_data[12:11]` select the class. 00 gives compressed-16 (code 1), 01 gives prefixed-48 (code 2), 10 gives prefixed-64 (code 3), and 11 gives variable block (code 4).
- R3: With `esc_en` high and `hw_data[15:13]` nonzero, the class is plain 32-bit (code 0).
- R4: With `esc_en` low, every halfword is classified as plain 32-bit (code 0), whatever its opcode.
- R5: `len_bytes` is 2, 4, 6 or 8 for codes 1, 0, 2 and 3, and 0 for code 4.
- R6: `payload` equals `hw_data[10:0]` for codes 1 to 4 and is zero for code 0.
- R7: While not stalled, each accepted halfword moves `stream_ptr` forward by its decoded length, modulo 2^PTR_W. The new value is seen one cycle later.
- R8: A variable-block halfword sets `unk_len` and leaves `stream_ptr` unchanged. While `unk_len` is high, further halfwords do not move `stream_ptr`.
- R9: `ptr_load` writes `ptr_load_val` into `stream_ptr` and clears `unk_len` on the next edge. It takes priority over a halfword accepted in the same cycle.
- R10: After reset, `cls_valid`, `cls_code`, `len_bytes`, `payload`, `stream_ptr` and `unk_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Leading halfword is present |
| hw_data | input | 16 | Leading halfword, first stream byte in bits 15:8 |
| esc_en | input | 1 | Escape mode enable |
| ptr_load | input | 1 | Load stream pointer and leave stall |
| ptr_load_val | input | PTR_W | Value to load into the pointer |
| cls_valid | output | 1 | Registered class is fresh |
| cls_code | output | 3 | Class code (0 plain, 1 c16, 2 p48, 3 p64, 4 block) |
| len_bytes | output | 4 | Instruction length in bytes, 0 if unknown |
| payload | output | 11 | Payload bits of a special-class halfword |
| stream_ptr | output | PTR_W | Byte offset of the next instruction |
| unk_len | output | 1 | Aligner stalled on an unknown length |

## Verification
On every cycle the assertions check four things. The class is consistent with its length and payload. The class stays plain 32-bit when escape is off or the top opcode bits are nonzero. The pointer moves by exactly the registered length. A stall keeps the pointer frozen until a load. The bench sweeps all 64 opcodes under both escape settings and several payload patterns. That sweep is the only way to show that each opcode pair maps to its intended class code. Separate scenarios cover pointer wrap-around, a halfword sent during a stall, and a load that arrives together with a halfword.

// File: rtl/ilen_pkg.sv
package ilen_pkg;
  localparam int HW_W  = 16;
  localparam int PAY_W = 11;
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    CLS_W32  = 3'd0,
    CLS_C16  = 3'd1,
    CLS_P48  = 3'd2,
    CLS_P64  = 3'd3,
    CLS_VBLK = 3'd4
  } ilen_cls_e;

  // Class from leading halfword; zero opcode row split into four pairs.
  function automatic ilen_cls_e classify(input logic [HW_W-1:0] hw, input logic esc);
    ilen_cls_e c;
    c = CLS_W32;
    if (esc && hw[15:13] == 3'b000) begin
      case (hw[12:11])
        2'b00:   c = CLS_C16;
        2'b01:   c = CLS_P48;
        2'b10:   c = CLS_P64;
        default: c = CLS_VBLK;
      endcase
    end
    return c;
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input ilen_cls_e c);
    logic [LEN_W-1:0] l;
    case (c)
      CLS_C16: l = 4'd2;
      CLS_W32: l = 4'd4;
      CLS_P48: l = 4'd6;
      CLS_P64: l = 4'd8;
      default: l = 4'd0;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/ilen_decode.sv
module ilen_decode
  import ilen_pkg::*;
(
  input  logic [HW_W-1:0]  hw,
  input  logic             esc,
  output ilen_cls_e        cls,
  output logic [LEN_W-1:0] len,
  output logic [PAY_W-1:0] pay
);
  always_comb begin
    cls = classify(hw, esc);
    len = len_of(cls);
    pay = (cls == CLS_W32) ? '0 : hw[PAY_W-1:0];
  end
endmodule

// File: rtl/ilen_stage.sv
module ilen_stage
  import ilen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  ilen_cls_e        in_cls,
  input  logic [LEN_W-1:0] in_len,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  output ilen_cls_e        out_cls,
  output logic [LEN_W-1:0] out_len,
  output logic [PAY_W-1:0] out_pay
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cls   <= CLS_W32;
      out_len   <= '0;
      out_pay   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cls <= in_cls;
        out_len <= in_len;
        out_pay <= in_pay;
      end
    end
  end
endmodule

// File: rtl/ilen_aligner.sv
module ilen_aligner
  import ilen_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [LEN_W-1:0] adv_len,
  input  logic             adv_unknown,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr,
  output logic             stall
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      stall <= 1'b0;
    end else if (load) begin
      ptr   <= load_val;
      stall <= 1'b0;
    end else if (adv && !stall) begin
      if (adv_unknown) stall <= 1'b1;
      else             ptr   <= ptr + PTR_W'(adv_len);
    end
  end
endmodule

// File: rtl/ilen_classifier.sv
module ilen_classifier
  import ilen_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_valid,
  input  logic [15:0]      hw_data,
  input  logic             esc_en,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_load_val,
  output logic             cls_valid,
  output logic [2:0]       cls_code,
  output logic [3:0]       len_bytes,
  output logic [10:0]      payload,
  output logic [PTR_W-1:0] stream_ptr,
  output logic             unk_len
);
  ilen_cls_e        dec_cls, reg_cls;
  logic [LEN_W-1:0] dec_len;
  logic [PAY_W-1:0] dec_pay;
  logic             vblk_seen;

  ilen_decode u_dec (
    .hw(hw_data), .esc(esc_en), .cls(dec_cls), .len(dec_len), .pay(dec_pay)
  );

  assign vblk_seen = (dec_cls == CLS_VBLK);

  ilen_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(hw_valid), .in_cls(dec_cls),
    .in_len(dec_len), .in_pay(dec_pay), .out_valid(cls_valid),
    .out_cls(reg_cls), .out_len(len_bytes), .out_pay(payload)
  );

  assign cls_code = reg_cls;

  ilen_aligner #(.PTR_W(PTR_W)) u_align (
    .clk(clk), .rst_n(rst_n), .adv(hw_valid), .adv_len(dec_len),
    .adv_unknown(vblk_seen), .load(ptr_load), .load_val(ptr_load_val),
    .ptr(stream_ptr), .stall(unk_len)
  );
endmodule

// File: rtl/ilen_checker.sv
module ilen_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_valid,
  input logic [15:0]      hw_data,
  input logic             esc_en,
  input logic             ptr_load,
  input logic [PTR_W-1:0] ptr_load_val,
  input logic             cls_valid,
  input logic [2:0]       cls_code,
  input logic [3:0]       len_bytes,
  input logic [10:0]      payload,
  input logic [PTR_W-1:0] stream_ptr,
  input logic             unk_len
);
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |=> cls_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_valid |=> !cls_valid); // R1
  AST_PLAIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_data[15:13] != 3'b000) |=> cls_code == 3'd0); // R3
  AST_ESC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !esc_en) |=> cls_code == 3'd0); // R4
  AST_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> ((len_bytes == 4'd0) == (cls_code == 3'd4))); // R5
  AST_PAY_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_code == 3'd0) |-> payload == 11'd0); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !unk_len && !ptr_load) |=>
      stream_ptr == $past(stream_ptr) + PTR_W'(len_bytes)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unk_len && !ptr_load) |=> (unk_len && $stable(stream_ptr))); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (!unk_len && stream_ptr == $past(ptr_load_val))); // R9
endmodule

bind ilen_classifier ilen_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
  .esc_en(esc_en), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
  .cls_valid(cls_valid), .cls_code(cls_code), .len_bytes(len_bytes),
  .payload(payload), .stream_ptr(stream_ptr), .unk_len(unk_len)
);

// File: tb/sim_ilen_classifier.sv
`timescale 1ns/1ps
module sim_ilen_classifier;
  localparam int PTR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_valid = 1'b0;
  logic [15:0] hw_data = '0;
  logic esc_en = 1'b0;
  logic ptr_load = 1'b0;
  logic [PTR_W-1:0] ptr_load_val = '0;
  logic cls_valid;
  logic [2:0] cls_code;
  logic [3:0] len_bytes;
  logic [10:0] payload;
  logic [PTR_W-1:0] stream_ptr;
  logic unk_len;

  int n_run = 0;
  int n_fail = 0;
  int exp_ptr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ilen_classifier #(.PTR_W(PTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .esc_en(esc_en), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .cls_valid(cls_valid), .cls_code(cls_code), .len_bytes(len_bytes),
    .payload(payload), .stream_ptr(stream_ptr), .unk_len(unk_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [15:0] h, input logic e);
    if (!e || h[15:13] != 3'd0) return 0;
    return 1 + int'(h[12:11]);
  endfunction

  function automatic int exp_len(input int c);
    if (c == 0) return 4;
    if (c == 4) return 0;
    if (c == 1) return 2;
    return 2 * c + 2;
  endfunction

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ptr(input int v);
    ptr_load = 1'b1; ptr_load_val = PTR_W'(v); hw_valid = 1'b0;
    cycle();
    ptr_load = 1'b0;
    exp_ptr = v % (1 << PTR_W);
    chk("R9 load ptr", int'(stream_ptr), exp_ptr);
    chk("R9 load clears stall", int'(unk_len), 0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    @(negedge clk); @(negedge clk);
    chk("R10 valid", int'(cls_valid), 0);
    chk("R10 code", int'(cls_code), 0);
    chk("R10 len", int'(len_bytes), 0);
    chk("R10 payload", int'(payload), 0);
    chk("R10 ptr", int'(stream_ptr), 0);
    chk("R10 stall", int'(unk_len), 0);
    rst_n = 1'b1;
    cycle();
    chk("R1 idle valid", int'(cls_valid), 0);

    // Sweep all opcodes, both escape settings, three payload patterns.
    for (int e = 0; e < 2; e++) begin
      for (int op = 0; op < 64; op++) begin
        for (int p = 0; p < 3; p++) begin
          logic [10:0] pat;
          logic [15:0] h;
          pat = (p == 0) ? 11'h000 : (p == 1) ? 11'h7FF : 11'h2AA;
          h = {op[5:0], 10'h000} | {5'd0, pat};
          hw_data = h; esc_en = e[0]; hw_valid = 1'b1;
          c = exp_code(h, e[0]);
          cycle();
          hw_valid = 1'b0;
          chk("R1 valid after halfword", int'(cls_valid), 1);
          if (!e[0])              chk("R4 esc off code", int'(cls_code), c);
          else if (op[5:3] != 0)  chk("R3 plain code", int'(cls_code), c);
          else                    chk("R2 special code", int'(cls_code), c);
          chk("R5 length", int'(len_bytes), exp_len(c));
          chk("R6 payload", int'(payload), (c == 0) ? 0 : int'(h[10:0]));
          if (c == 4) begin
            chk("R8 stall set", int'(unk_len), 1);
            chk("R8 ptr held", int'(stream_ptr), exp_ptr);
            load_ptr((exp_ptr + 16) % (1 << PTR_W));
          end else begin
            exp_ptr = (exp_ptr + exp_len(c)) % (1 << PTR_W);
            chk("R7 ptr advance", int'(stream_ptr), exp_ptr);
          end
        end
      end
    end

    // Halfword during stall is ignored by the pointer.
    esc_en = 1'b1; hw_data = 16'h1800; hw_valid = 1'b1;
    cycle();
    chk("R8 stall enter", int'(unk_len), 1);
    hw_data = 16'hFFFF;
    cycle();
    hw_valid = 1'b0;
    chk("R8 stalled ptr", int'(stream_ptr), exp_ptr);
    chk("R8 still stalled", int'(unk_len), 1);
    chk("R1 class still reported", int'(cls_code), 0);

    // Load with simultaneous halfword: load wins.
    ptr_load = 1'b1; ptr_load_val = 16'h0100; hw_valid = 1'b1; hw_data = 16'hFFFF;
    cycle();
    ptr_load = 1'b0; hw_valid = 1'b0;
    exp_ptr = 16'h0100;
    chk("R9 load priority ptr", int'(stream_ptr), exp_ptr);
    chk("R9 load priority stall", int'(unk_len), 0);

    // Wrap-around.
    load_ptr(16'hFFFE);
    hw_data = 16'h1000; esc_en = 1'b1; hw_valid = 1'b1;
    cycle();
    hw_valid = 1'b0;
    chk("R7 wrap p64", int'(stream_ptr), 6);
    cycle();
    chk("R1 valid drops", int'(cls_valid), 0);
    chk("R1 ptr idle", int'(stream_ptr), 6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule